// File: doc/BRIEF.md
# Model-Specific Register Access Unit

This unit serves privileged read and write requests to a small bank of 64-bit model-specific registers. Each request names one register by a 32-bit index. It also carries the operation type, 64 bits of write data split into a high and a low 32-bit half, the current privilege level and the processor mode. One cycle after a request is accepted, the unit returns either the register contents as two 32-bit halves or a general-protection fault. The fault always has error code zero.

The bank holds five registers:
- A free-running time-stamp counter, which can be loaded by a write. It is also visible at all times on a dedicated read port.
- A pair of machine-check capture registers. They latch the address and the cycle type of a failing bus cycle when a check strobe fires. A read of the type register clears its check bit.
- Two plain 64-bit storage registers: an array-access register and a hardware-configuration register.

Every request is gated by the mode and privilege checks and by the index decode. A rejected request changes nothing.

Top module: `msr_access_unit`

## Requirements
- R1: Each request sampled with `req_valid_i` high at a rising clock edge produces exactly one response, with `rsp_valid_o` high during the following cycle only. `rsp_valid_o` is low when no request was sampled.
- R2: Exactly five indices are decoded. 0x00 selects the check address, 0x01 the check type, 0x10 the time-stamp counter, 0x82 the array-access register and 0x83 the configuration register. Write data bits 63:32 come from `req_wdata_hi_i` and bits 31:0 from `req_wdata_lo_i`. Read data is split the same way. A read returns the value last written.
- R3: The mode encoding on `req_mode_i` is 0 = real and 1 = protected. In real mode any privilege level is accepted. In protected mode a request is accepted only when `req_cpl_i` is 0; otherwise it faults.
- R4: Mode code 2 (virtual-8086) faults at every privilege level. The unused mode code 3 also faults.
- R5: Any index other than the five in R2 faults, in both real and protected mode. All 32 index bits are compared.
- R6: A faulting request leaves every register unchanged. Its response has `rsp_fault_o` high and read data zero; `rsp_fault_o` high means a general-protection fault with error code 0. An accepted write responds with `rsp_fault_o` low and read data zero.
- R7: The time-stamp counter resets to 0 and increases by one on every clock. `tsc_o` always shows the current count.
- R8: An accepted write to index 0x10 makes `tsc_o` equal the written value in the next cycle, overriding that cycle's increment. The counter wraps from all-ones to zero. A read of 0x10 returns the value `tsc_o` showed in the cycle the request was accepted.
- R9: When `mc_strobe_i` is high at a clock edge, the check address register loads `mc_addr_i` zero-extended. The check type register loads `mc_type_i` in bits 8:1, with bit 0 (check bit) set and all other bits zero. The capture wins over a write or a read-clear in the same cycle.
- R10: An accepted read of index 0x01 returns the register value from before the read, then clears bit 0 only.
- R11: After reset all registers are zero and `rsp_valid_o`, `rsp_fault_o` and the read data are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_index_i | input | 32 | Register index |
| req_wdata_hi_i | input | 32 | Write data bits 63:32 |
| req_wdata_lo_i | input | 32 | Write data bits 31:0 |
| req_cpl_i | input | 2 | Current privilege level |
| req_mode_i | input | 2 | Processor mode: 0 real, 1 protected, 2 virtual-8086, 3 unused |
| mc_strobe_i | input | 1 | Bus-check or parity-check capture strobe |
| mc_addr_i | input | 32 | Address of the failing bus cycle |
| mc_type_i | input | 8 | Cycle type of the failing bus cycle |
| rsp_valid_o | output | 1 | Response present |
| rsp_fault_o | output | 1 | General-protection fault, error code 0 |
| rsp_rdata_hi_o | output | 32 | Read data bits 63:32 |
| rsp_rdata_lo_o | output | 32 | Read data bits 31:0 |
| tsc_o | output | 64 | Live time-stamp count |

## Verification
The counter is checked every cycle against an exact +1 or load step, so a wrong increment or load priority shows on `tsc_o` one cycle later. Corrupted capture or storage state stays hidden until the register is read back. For that reason every write, capture and fault case is followed at once by a read whose response arrives one cycle after it. A faulting request that wrongly updates a register is caught by the readback that follows it. A check bit that fails to clear is caught by a second read of the type register.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int N_REG  = 5;
  localparam int REG_MCA = 0;
  localparam int REG_MCT = 1;
  localparam int REG_TSC = 2;
  localparam int REG_ARR = 3;
  localparam int REG_CFG = 4;

  localparam logic [31:0] IDX_TAB [N_REG] = '{32'h00, 32'h01, 32'h10, 32'h82, 32'h83};

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_V86  = 2'd2,
    MODE_RSVD = 2'd3
  } cpu_mode_e;
endpackage

// File: rtl/msr_guard.sv
module msr_guard
  import msr_pkg::*;
#(
  parameter int IDX_W = 32
) (
  input  logic             valid_i,
  input  logic [IDX_W-1:0] index_i,
  input  logic [1:0]       cpl_i,
  input  logic [1:0]       mode_i,
  output logic [N_REG-1:0] hit_o,
  output logic             fault_o
);
  logic [N_REG-1:0] idx_hit;
  logic             priv_ok;

  for (genvar g = 0; g < N_REG; g++) begin : g_dec
    assign idx_hit[g] = (index_i == IDX_W'(IDX_TAB[g]));
  end

  always_comb begin
    unique case (cpu_mode_e'(mode_i))
      MODE_REAL: priv_ok = 1'b1;
      MODE_PROT: priv_ok = (cpl_i == 2'd0);
      default:   priv_ok = 1'b0;
    endcase
  end

  assign fault_o = valid_i && (!priv_ok || idx_hit == '0);
  assign hit_o   = (valid_i && !fault_o) ? idx_hit : '0;
endmodule

// File: rtl/msr_tsc.sv
module msr_tsc #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (ld_i) cnt_q <= ld_val_i;
    else           cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/msr_mc_capture.sv
module msr_mc_capture #(
  parameter int W      = 64,
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic [TYPE_W-1:0] cap_type_i,
  input  logic              wr_addr_i,
  input  logic              wr_type_i,
  input  logic              clr_chk_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      mca_o,
  output logic [W-1:0]      mct_o
);
  localparam int PAD_W = W - TYPE_W - 1;

  logic [W-1:0] mca_q, mct_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mca_q <= '0;
      mct_q <= '0;
    end else begin
      // capture outranks software access
      if (cap_i)          mca_q <= W'(cap_addr_i);
      else if (wr_addr_i) mca_q <= wdata_i;

      if (cap_i)          mct_q <= {{PAD_W{1'b0}}, cap_type_i, 1'b1};
      else if (wr_type_i) mct_q <= wdata_i;
      else if (clr_chk_i) mct_q[0] <= 1'b0;
    end
  end

  assign mca_o = mca_q;
  assign mct_o = mct_q;
endmodule

// File: rtl/msr_plain_reg.sv
module msr_plain_reg #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/msr_access_unit.sv
module msr_access_unit
  import msr_pkg::*;
#(
  parameter int IDX_W  = 32,
  parameter int HALF_W = 32,
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [IDX_W-1:0]    req_index_i,
  input  logic [HALF_W-1:0]   req_wdata_hi_i,
  input  logic [HALF_W-1:0]   req_wdata_lo_i,
  input  logic [1:0]          req_cpl_i,
  input  logic [1:0]          req_mode_i,
  input  logic                mc_strobe_i,
  input  logic [ADDR_W-1:0]   mc_addr_i,
  input  logic [TYPE_W-1:0]   mc_type_i,
  output logic                rsp_valid_o,
  output logic                rsp_fault_o,
  output logic [HALF_W-1:0]   rsp_rdata_hi_o,
  output logic [HALF_W-1:0]   rsp_rdata_lo_o,
  output logic [2*HALF_W-1:0] tsc_o
);
  localparam int W = 2 * HALF_W;

  logic [N_REG-1:0] hit;
  logic [N_REG-1:0] wr_en;
  logic [N_REG-1:0] rd_en;
  logic             fault;
  logic [W-1:0]     wdata;
  logic [W-1:0]     reg_val [N_REG];
  logic [W-1:0]     rd_mux;

  logic             rsp_valid_q, rsp_fault_q;
  logic [W-1:0]     rsp_data_q;

  assign wdata = {req_wdata_hi_i, req_wdata_lo_i};

  msr_guard #(.IDX_W(IDX_W)) u_guard (
    .valid_i (req_valid_i),
    .index_i (req_index_i),
    .cpl_i   (req_cpl_i),
    .mode_i  (req_mode_i),
    .hit_o   (hit),
    .fault_o (fault)
  );

  assign wr_en = req_write_i ? hit : '0;
  assign rd_en = req_write_i ? '0  : hit;

  msr_mc_capture #(.W(W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) u_mc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (mc_strobe_i),
    .cap_addr_i (mc_addr_i),
    .cap_type_i (mc_type_i),
    .wr_addr_i  (wr_en[REG_MCA]),
    .wr_type_i  (wr_en[REG_MCT]),
    .clr_chk_i  (rd_en[REG_MCT]),
    .wdata_i    (wdata),
    .mca_o      (reg_val[REG_MCA]),
    .mct_o      (reg_val[REG_MCT])
  );

  msr_tsc #(.W(W)) u_tsc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (wr_en[REG_TSC]),
    .ld_val_i (wdata),
    .cnt_o    (reg_val[REG_TSC])
  );

  for (genvar g = REG_ARR; g <= REG_CFG; g++) begin : g_plain
    msr_plain_reg #(.W(W)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_en[g]),
      .d_i    (wdata),
      .q_o    (reg_val[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_REG; i++) begin
      if (rd_en[i]) rd_mux = rd_mux | reg_val[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_fault_q <= fault;
      rsp_data_q  <= rd_mux;
    end
  end

  assign rsp_valid_o    = rsp_valid_q;
  assign rsp_fault_o    = rsp_fault_q;
  assign rsp_rdata_hi_o = rsp_data_q[W-1:HALF_W];
  assign rsp_rdata_lo_o = rsp_data_q[HALF_W-1:0];
  assign tsc_o          = reg_val[REG_TSC];
endmodule

// File: rtl/msr_access_unit_chk.sv
module msr_access_unit_chk #(
  parameter int IDX_W  = 32,
  parameter int HALF_W = 32,
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_write_i,
  input logic [IDX_W-1:0]    req_index_i,
  input logic [HALF_W-1:0]   req_wdata_hi_i,
  input logic [HALF_W-1:0]   req_wdata_lo_i,
  input logic [1:0]          req_cpl_i,
  input logic [1:0]          req_mode_i,
  input logic                mc_strobe_i,
  input logic [ADDR_W-1:0]   mc_addr_i,
  input logic [TYPE_W-1:0]   mc_type_i,
  input logic                rsp_valid_o,
  input logic                rsp_fault_o,
  input logic [HALF_W-1:0]   rsp_rdata_hi_o,
  input logic [HALF_W-1:0]   rsp_rdata_lo_o,
  input logic [2*HALF_W-1:0] tsc_o
);
  logic known_idx, priv_ok, tsc_wr;

  assign known_idx = req_index_i == IDX_W'(32'h00) || req_index_i == IDX_W'(32'h01) ||
                     req_index_i == IDX_W'(32'h10) || req_index_i == IDX_W'(32'h82) ||
                     req_index_i == IDX_W'(32'h83);
  assign priv_ok   = (req_mode_i == 2'd0) || (req_mode_i == 2'd1 && req_cpl_i == 2'd0);
  assign tsc_wr    = req_valid_i && req_write_i && priv_ok && req_index_i == IDX_W'(32'h10);

  p_rsp_after_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_no_rsp_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_cpl_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_mode_i == 2'd1 && req_cpl_i != 2'd0 |=> rsp_fault_o);
  p_v86_fault_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_mode_i[1] |=> rsp_fault_o);
  p_unimpl_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !known_idx |=> rsp_fault_o);
  p_fault_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_valid_o && rsp_rdata_hi_o == '0 && rsp_rdata_lo_o == '0);
  p_tsc_inc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tsc_wr |=> tsc_o == $past(tsc_o) + 1'b1);
  p_tsc_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsc_wr |=> tsc_o == $past({req_wdata_hi_i, req_wdata_lo_i}));
  p_reset_idle_r11: assert property (@(posedge clk_i)
    !rst_ni |-> !rsp_valid_o && !rsp_fault_o && tsc_o == '0);

  logic unused_ok;
  assign unused_ok = ^{mc_strobe_i, mc_addr_i, mc_type_i};
endmodule

bind msr_access_unit msr_access_unit_chk #(
  .IDX_W(IDX_W), .HALF_W(HALF_W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W)
) u_chk (.*);

// File: tb/msr_access_unit_tb.sv
module msr_access_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_index = '0, wd_hi = '0, wd_lo = '0;
  logic [1:0]  req_cpl = '0, req_mode = '0;
  logic        mc_strobe = 1'b0;
  logic [31:0] mc_addr = '0;
  logic [7:0]  mc_type = '0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rd_hi, rd_lo;
  logic [63:0] tsc;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic        r_valid, r_fault;
  logic [63:0] r_data, t_pre;

  always #5 clk = ~clk;

  msr_access_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_index_i(req_index), .req_wdata_hi_i(wd_hi), .req_wdata_lo_i(wd_lo),
    .req_cpl_i(req_cpl), .req_mode_i(req_mode), .mc_strobe_i(mc_strobe),
    .mc_addr_i(mc_addr), .mc_type_i(mc_type), .rsp_valid_o(rsp_valid),
    .rsp_fault_o(rsp_fault), .rsp_rdata_hi_o(rd_hi), .rsp_rdata_lo_o(rd_lo), .tsc_o(tsc)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with the response captured
  task automatic do_req(input bit wr, input logic [31:0] idx, input logic [63:0] d,
                        input logic [1:0] cpl, input logic [1:0] mode);
    req_valid = 1'b1; req_write = wr; req_index = idx;
    {wd_hi, wd_lo} = d; req_cpl = cpl; req_mode = mode;
    t_pre = tsc;
    @(negedge clk);
    r_valid = rsp_valid; r_fault = rsp_fault; r_data = {rd_hi, rd_lo};
    req_valid = 1'b0; req_write = 1'b0; mc_strobe = 1'b0;
  endtask

  task automatic expect_ok(input string tag, input logic [63:0] exp);
    chk(r_valid && !r_fault && r_data == exp, tag, {r_valid, r_fault, r_data[61:0]}, {2'b10, exp[61:0]});
  endtask

  task automatic expect_fault(input string tag);
    chk(r_valid && r_fault && r_data == '0, tag, {r_valid, r_fault, r_data[61:0]}, {2'b11, 62'h0});
  endtask

  task automatic t_reset;
    chk(!rsp_valid && !rsp_fault && tsc == '0, "R11 reset outputs", {rsp_valid, rsp_fault, tsc[61:0]}, 64'h0);
    @(negedge clk); rst_n = 1'b1;
    do_req(1'b0, 32'h82, '0, 2'd0, 2'd0);
    expect_ok("R11 reset value", 64'h0);
    @(negedge clk);
    chk(!rsp_valid, "R1 no response when idle", {63'h0, rsp_valid}, 64'h0);
  endtask

  task automatic t_storage;
    do_req(1'b1, 32'h82, 64'h1234_5678_9ABC_DEF0, 2'd3, 2'd0);
    expect_ok("R3 real mode cpl3 write accepted, R6 write data zero", 64'h0);
    do_req(1'b1, 32'h83, 64'hCAFE_0001_0BAD_F00D, 2'd0, 2'd1);
    expect_ok("R2 cfg write", 64'h0);
    do_req(1'b0, 32'h82, '0, 2'd0, 2'd1);
    expect_ok("R2 arr readback halves", 64'h1234_5678_9ABC_DEF0);
    do_req(1'b0, 32'h83, '0, 2'd0, 2'd0);
    expect_ok("R2 cfg readback", 64'hCAFE_0001_0BAD_F00D);
    do_req(1'b1, 32'h00, 64'hFFFF_0000_AAAA_5555, 2'd0, 2'd0);
    do_req(1'b0, 32'h00, '0, 2'd0, 2'd0);
    expect_ok("R2 check address write/read", 64'hFFFF_0000_AAAA_5555);
  endtask

  task automatic t_faults;
    do_req(1'b1, 32'h82, 64'hDEAD, 2'd3, 2'd1); expect_fault("R3 protected cpl3 write");
    do_req(1'b0, 32'h82, '0, 2'd1, 2'd1);       expect_fault("R3 protected cpl1 read");
    do_req(1'b1, 32'h82, 64'hBEEF, 2'd0, 2'd2); expect_fault("R4 v86 cpl0 write");
    do_req(1'b0, 32'h10, '0, 2'd0, 2'd3);       expect_fault("R4 mode 3 read");
    do_req(1'b0, 32'h11, '0, 2'd0, 2'd0);       expect_fault("R5 index 0x11 real");
    do_req(1'b1, 32'h84, 64'h1, 2'd0, 2'd1);    expect_fault("R5 index 0x84 protected");
    do_req(1'b0, 32'h8000_0010, '0, 2'd0, 2'd0); expect_fault("R5 upper index bits");
    do_req(1'b0, 32'h82, '0, 2'd0, 2'd0);
    expect_ok("R6 faulting writes left arr unchanged", 64'h1234_5678_9ABC_DEF0);
    do_req(1'b1, 32'h10, 64'h0, 2'd2, 2'd1);
    chk(tsc == t_pre + 64'd1, "R6 faulting tsc write ignored", tsc, t_pre + 64'd1);
  endtask

  task automatic t_tsc;
    logic [63:0] a;
    a = tsc; @(negedge clk);
    chk(tsc == a + 64'd1, "R7 tsc increments", tsc, a + 64'd1);
    do_req(1'b1, 32'h10, 64'hFFFF_FFFF_FFFF_FFFE, 2'd0, 2'd0);
    chk(tsc == 64'hFFFF_FFFF_FFFF_FFFE, "R8 tsc load priority", tsc, 64'hFFFF_FFFF_FFFF_FFFE);
    @(negedge clk);
    chk(tsc == 64'hFFFF_FFFF_FFFF_FFFF, "R7 tsc after load", tsc, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    chk(tsc == 64'h0, "R8 tsc wraps", tsc, 64'h0);
    do_req(1'b0, 32'h10, '0, 2'd0, 2'd1);
    expect_ok("R8 tsc read matches port", t_pre);
  endtask

  task automatic t_capture;
    mc_strobe = 1'b1; mc_addr = 32'h8765_4321; mc_type = 8'hA5;
    do_req(1'b1, 32'h00, 64'h1111_1111_1111_1111, 2'd0, 2'd0);
    do_req(1'b0, 32'h00, '0, 2'd0, 2'd0);
    expect_ok("R9 capture beats write, zero-extended", 64'h0000_0000_8765_4321);
    do_req(1'b0, 32'h01, '0, 2'd0, 2'd0);
    expect_ok("R9 type capture bits 8:1 plus check bit", 64'h14B);
    do_req(1'b0, 32'h01, '0, 2'd0, 2'd0);
    expect_ok("R10 check bit cleared after read", 64'h14A);
    do_req(1'b1, 32'h01, 64'hF0F0_0000_0000_0003, 2'd0, 2'd0);
    do_req(1'b0, 32'h01, '0, 2'd0, 2'd1);
    expect_ok("R10 read returns pre-clear value", 64'hF0F0_0000_0000_0003);
    do_req(1'b0, 32'h01, '0, 2'd0, 2'd1);
    expect_ok("R10 only bit 0 cleared", 64'hF0F0_0000_0000_0002);
    mc_strobe = 1'b1; mc_type = 8'h3C;
    do_req(1'b0, 32'h01, '0, 2'd0, 2'd0);
    expect_ok("R10 read value before simultaneous capture", 64'hF0F0_0000_0000_0002);
    do_req(1'b0, 32'h01, '0, 2'd0, 2'd0);
    expect_ok("R9 capture beats read-clear", 64'h79);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_storage;
    t_faults;
    t_tsc;
    t_capture;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule